// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a general-purpose I/O port, 32 pins wide by default. It has a small register file that is reached over a word-addressed read/write bus. Software writes an output value and a per-pin output enable. It reads back the synchronised level of every pad. For each pin it chooses an interrupt condition: low level, high level, rising edge or falling edge. A separate per-pin override makes a pin flag on both edges instead.

Every pad input passes through a two-flop synchroniser. Edges are found by comparing the synchronised sample with the sample from the cycle before. A detected condition sets a sticky status bit. Software clears a status bit by writing a 1 to it. The single interrupt request output is high whenever a pending status bit is also enabled in the mask register. Bus reads are registered, so read data appears one clock after the address is presented. Writes take effect at the clock edge on which `bus_wr` is high.

Top module: `gpio_irq_port`

## Requirements
- R1: After a synchronous reset, every register reads zero. On the first bus read after reset the status register also reads zero. `pad_out`, `pad_oe` and `irq` are 0.
- R2: Word 0 holds the output value and drives `pad_out`. Word 1 holds the output enables and drives `pad_oe`, where 1 means the pin drives and 0 means it is an input. Both words read back the value last written.
- R3: Word 2 returns the pad levels delayed by two synchroniser flops, for every pin whatever its direction. Writes to word 2 have no effect.
- R4: Each pin has a 2-bit condition code. Pin n below 16 uses bits [2n+1:2n] of word 3, and pin n from 16 up uses bits [2(n-16)+1:2(n-16)] of word 4. Code 2 flags a rising edge of the synchronised input and does not flag the falling edge.
- R5: Code 3 flags a falling edge and does not flag the rising edge.
- R6: Code 1 flags a high level on every cycle the synchronised input is 1. A write-1-to-clear takes effect only once the input has gone low.
- R7: Code 0 flags a low level on every cycle the synchronised input is 0.
- R8: When a pin's bit in word 7 is 1, that pin flags both rising and falling edges and its condition code is ignored. In particular, a held level is not flagged.
- R9: Word 6 is the sticky status. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R10: Word 5 is the interrupt mask. `irq` is 1 exactly when status AND mask is non-zero, and it follows a mask write at the same edge. Status bits still latch while masked.
- R11: If a detected event and a write-1-to-clear hit the same status bit on the same edge, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data for the previous cycle's address |
| pad_in | input | WIDTH | Asynchronous pad levels |
| pad_out | output | WIDTH | Output value register |
| pad_oe | output | WIDTH | Output enable register (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets the field placement on both sides of the pin-16 split. A design that indexes word 4 with the absolute pin number would configure the wrong pin, and pin 20 would flag nothing or flag on the wrong edge. Level conditions are checked against a clear issued while the level is still active; a design that lets the clear win would lose a held interrupt. The both-edges override is held at a steady high level with a high-level code underneath it. If the code leaked through, status would be set again after the clear. A rising edge is timed to reach status on the very edge that carries a clear for that bit, and a design that lets the clear win drops the event. Partial-mask clears and zero writes to status catch a design that clears the whole word on any write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    REG_DATA   = 3'd0,
    REG_DIR    = 3'd1,
    REG_PAD    = 3'd2,
    REG_CFG_LO = 3'd3,
    REG_CFG_HI = 3'd4,
    REG_MASK   = 3'd5,
    REG_STAT   = 3'd6,
    REG_BOTH   = 3'd7
  } gpio_reg_e;

  typedef enum logic [1:0] {
    COND_LOW  = 2'd0,
    COND_HIGH = 2'd1,
    COND_RISE = 2'd2,
    COND_FALL = 2'd3
  } gpio_cond_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

  // R3: output is the input from two clocks earlier
  p_two_stage_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]   cur,
  input  logic [WIDTH-1:0]   prev,
  input  logic [2*WIDTH-1:0] cond,
  input  logic [WIDTH-1:0]   both,
  output logic [WIDTH-1:0]   hit
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic rise, fall;
    gpio_cond_e code;
    assign rise = cur[g] & ~prev[g];
    assign fall = ~cur[g] & prev[g];
    assign code = gpio_cond_e'(cond[2*g +: 2]);

    always_comb begin
      if (both[g]) begin
        hit[g] = rise | fall;
      end else begin
        unique case (code)
          COND_LOW:  hit[g] = ~cur[g];
          COND_HIGH: hit[g] = cur[g];
          COND_RISE: hit[g] = rise;
          default:   hit[g] = fall;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic             irq
);
  localparam int HALF = WIDTH / 2;
  localparam int CFGW = 2 * HALF;

  logic [WIDTH-1:0] smp, prev_q, hit;
  logic [CFGW-1:0]  cfg_lo_q, cfg_hi_q;
  logic [WIDTH-1:0] mask_q, stat_q, both_q;
  logic [WIDTH-1:0] clr, stat_d, mask_d;
  gpio_reg_e        sel;

  assign sel = gpio_reg_e'(bus_addr);

  gpio_irq_sync #(.WIDTH(WIDTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (smp)
  );

  gpio_irq_detect #(.WIDTH(WIDTH)) u_detect (
    .cur  (smp),
    .prev (prev_q),
    .cond ({cfg_hi_q, cfg_lo_q}),
    .both (both_q),
    .hit  (hit)
  );

  always_comb begin
    clr    = (bus_wr && sel == REG_STAT) ? bus_wdata : '0;
    stat_d = (stat_q & ~clr) | hit;
    mask_d = (bus_wr && sel == REG_MASK) ? bus_wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out  <= '0;
      pad_oe   <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      stat_q   <= '0;
      both_q   <= '0;
      prev_q   <= '0;
      irq      <= 1'b0;
    end else begin
      prev_q <= smp;
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq    <= |(stat_d & mask_d);
      if (bus_wr) begin
        unique case (sel)
          REG_DATA:   pad_out  <= bus_wdata;
          REG_DIR:    pad_oe   <= bus_wdata;
          REG_CFG_LO: cfg_lo_q <= bus_wdata[CFGW-1:0];
          REG_CFG_HI: cfg_hi_q <= bus_wdata[CFGW-1:0];
          REG_BOTH:   both_q   <= bus_wdata;
          default:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (sel)
        REG_DATA:   bus_rdata <= pad_out;
        REG_DIR:    bus_rdata <= pad_oe;
        REG_PAD:    bus_rdata <= smp;
        REG_CFG_LO: bus_rdata <= WIDTH'(cfg_lo_q);
        REG_CFG_HI: bus_rdata <= WIDTH'(cfg_hi_q);
        REG_MASK:   bus_rdata <= mask_q;
        REG_STAT:   bus_rdata <= stat_q;
        default:    bus_rdata <= both_q;
      endcase
    end
  end

  // R10: request tracks pending-and-enabled status
  p_irq_match_r10: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_q & mask_q));

  // R11: a detected event always leaves its bit set
  p_event_wins_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((stat_q & $past(hit)) == $past(hit)));

  // R9: a cleared bit without a new event reads zero
  p_w1c_clears_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((stat_q & $past(clr & ~hit)) == '0));

  // R9: status bits only rise from a detected event
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0));
endmodule

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0;
  logic [2:0]   bus_addr = 3'd0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out, pad_oe;
  logic         irq;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  gpio_irq_port #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // all pins high-level, inputs low, status cleared
  task automatic quiet();
    wr(3'd3, 32'h5555_5555);
    wr(3'd4, 32'h5555_5555);
    wr(3'd7, '0);
    wr(3'd5, '0);
    pad_in = '0;
    settle();
    wr(3'd6, '1);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(3'd6, v); check("R1 status", v, '0);
    check("R1 irq", W'(irq), '0);
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_out", pad_out, '0);
    rd(3'd3, v); check("R1 cfg_lo", v, '0);
    rd(3'd5, v); check("R1 mask", v, '0);
    rd(3'd7, v); check("R1 both", v, '0);
  endtask

  task automatic t_data_dir();
    logic [W-1:0] v;
    wr(3'd0, 32'hA5A5_0F0F);
    wr(3'd1, 32'hFFFF_0000);
    check("R2 pad_out", pad_out, 32'hA5A5_0F0F);
    check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    rd(3'd0, v); check("R2 data rb", v, 32'hA5A5_0F0F);
    rd(3'd1, v); check("R2 dir rb", v, 32'hFFFF_0000);
  endtask

  task automatic t_pad();
    logic [W-1:0] v;
    pad_in = 32'h1234_5678;
    settle();
    rd(3'd2, v); check("R3 pad status", v, 32'h1234_5678);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); check("R3 write ignored", v, 32'h1234_5678);
    pad_in = '0;
    settle();
  endtask

  task automatic t_rise();
    logic [W-1:0] v;
    quiet();
    wr(3'd3, 32'h5555_5595);   // pin 3 code 2
    wr(3'd4, 32'h5555_5655);   // pin 20 code 2
    pad_in = 32'h0010_0008;
    settle();
    rd(3'd6, v); check("R4 rise pins 3,20", v, 32'h0010_0008);
    wr(3'd6, '1);
    pad_in = '0;
    settle();
    rd(3'd6, v); check("R4 no fall flag", v, '0);
  endtask

  task automatic t_fall();
    logic [W-1:0] v;
    quiet();
    wr(3'd3, 32'h5555_D555);   // pin 7 code 3
    pad_in = 32'h0000_0080;
    settle();
    rd(3'd6, v); check("R5 no rise flag", v, '0);
    pad_in = '0;
    settle();
    rd(3'd6, v); check("R5 fall pin 7", v, 32'h0000_0080);
  endtask

  task automatic t_high();
    logic [W-1:0] v;
    quiet();
    pad_in = 32'h0000_0400;
    settle();
    wr(3'd6, 32'h0000_0400);
    rd(3'd6, v); check("R6 held high re-sets", v, 32'h0000_0400);
    pad_in = '0;
    settle();
    wr(3'd6, 32'h0000_0400);
    rd(3'd6, v); check("R6 cleared after low", v, '0);
  endtask

  task automatic t_low();
    logic [W-1:0] v;
    quiet();
    wr(3'd3, 32'h5455_5555);   // pin 12 code 0
    settle();
    wr(3'd6, '1);
    rd(3'd6, v); check("R7 held low re-sets", v, 32'h0000_1000);
    pad_in = 32'h0000_1000;
    settle();
    wr(3'd6, '1);
    rd(3'd6, v); check("R7 cleared after high", v, '0);
  endtask

  task automatic t_both();
    logic [W-1:0] v;
    quiet();
    wr(3'd7, 32'h0000_0020);   // pin 5 both edges, code 1 underneath
    pad_in = 32'h0000_0020;
    settle();
    rd(3'd6, v); check("R8 rise", v, 32'h0000_0020);
    wr(3'd6, '1);
    settle();
    rd(3'd6, v); check("R8 level ignored", v, '0);
    pad_in = '0;
    settle();
    rd(3'd6, v); check("R8 fall", v, 32'h0000_0020);
  endtask

  task automatic t_w1c_mask();
    logic [W-1:0] v;
    quiet();
    wr(3'd3, 32'h5555_5595);
    wr(3'd4, 32'h5555_5655);
    pad_in = 32'h0010_0008;
    settle();
    check("R10 masked no irq", W'(irq), '0);
    wr(3'd6, 32'h0000_0008);
    rd(3'd6, v); check("R9 partial clear", v, 32'h0010_0000);
    wr(3'd6, '0);
    rd(3'd6, v); check("R9 zero write", v, 32'h0010_0000);
    wr(3'd5, 32'h0010_0000);
    check("R10 irq on mask", W'(irq), 1);
    wr(3'd5, 32'h0000_0008);
    check("R10 other mask", W'(irq), 0);
    wr(3'd5, '0);
    pad_in = '0;
    settle();
  endtask

  task automatic t_collide();
    logic [W-1:0] v;
    quiet();
    wr(3'd3, 32'h5555_5595);
    wr(3'd6, '1);
    pad_in = 32'h0000_0008;
    @(negedge clk);
    @(negedge clk);
    wr(3'd6, 32'h0000_0008);   // clear on the edge the event lands
    rd(3'd6, v); check("R11 event wins", v, 32'h0000_0008);
    wr(3'd6, 32'h0000_0008);
    rd(3'd6, v); check("R11 later clear", v, '0);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog got=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_data_dir();
    t_pad();
    t_rise();
    t_fall();
    t_high();
    t_low();
    t_both();
    t_w1c_mask();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule